// File: doc/BRIEF.md
# Reference Divider with Dual Tap Select

This block turns a reference clock into two comparison pulse streams for a pair of phase detectors. A programmable prescaler counts R reference cycles per period and marks the last cycle of each period as a terminal count. A binary chain behind it counts those terminal counts, giving five aligned pulse streams with periods R, 2R, 4R, 8R and 16R reference cycles. Each stream is one reference cycle wide.

Two independent 3-bit codes pick one stream each: one for the main phase detector and one for the auxiliary phase detector, so the two loops can compare at different rates. The two codes use opposite mappings. On the main side, a larger code picks a more divided stream. On the auxiliary side, a larger code picks a less divided stream. The division ratio is written through a load strobe into a holding register that reset does not clear. The running prescaler picks up the held value only when a period starts, so a period never gets cut short.

The prescaler is a three-state machine. Reset forces `LOAD`. In that state the running ratio is taken from the holding register, the count is cleared and the chain is cleared. `LOAD` always moves to `COUNT`. `COUNT` stays in `COUNT` while the count is below R-2 and moves to `TERM` when the count reaches R-2. `TERM` is the terminal-count cycle: it takes the held ratio, clears the count, advances the chain and always moves back to `COUNT`.

Top module: `refdiv_tapsel`

## Requirements
- R1: While reset is asserted both outputs are low. The first cycle after reset is released (cycle index 0, the `LOAD` cycle) carries no pulse.
- R2: Counting cycles from index 0 after reset release, terminal counts occur at indices R, 2R, 3R and so on. Each output pulse is exactly one reference cycle wide.
- R3: A programmed ratio below 4 (for example 0 or 3) behaves exactly as a ratio of 4.
- R4: Main code k, for k from 0 to 4 (binary 000 to 100), pulses at the nonzero indices that are multiples of R·2^k.
- R5: Auxiliary code k, for k from 0 to 4, pulses at the nonzero multiples of R·2^(4−k). Code 100 therefore gives period R, and code 000 gives period 16R.
- R6: Codes 101, 110 and 111 select the period-16R stream on either output.
- R7: A ratio written while the divider runs leaves the period in progress unchanged. The new ratio applies from the first period that starts after the next terminal count.
- R8: Every output pulse falls on a prescaler terminal count, so all streams stay phase-aligned to one another.
- R9: The programmed ratio is kept through reset. Reset restarts the prescaler and every chain stage together from zero.
- R10: Ratios up to 1023 (the full 10-bit range) divide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of the divider state |
| ratio_we | input | 1 | Load strobe for the division ratio |
| ratio_in | input | 10 | Division ratio R (values below 4 are raised to 4) |
| main_sel | input | 3 | Main stream code (000 least divided) |
| aux_sel | input | 3 | Auxiliary stream code (100 least divided) |
| main_pulse | output | 1 | Pulse to the main phase detector |
| aux_pulse | output | 1 | Pulse to the auxiliary phase detector |

## Verification
The assertions check on every cycle the properties that hold at any instant. Each pulse is one cycle wide. Pulses fall only on terminal counts. Terminal counts are never closer than the minimum ratio. The two outputs agree whenever their codes name the same stream, whether through the mirrored mapping or through the high codes. The exact period of each stream, the clamping of small ratios and the deferred pickup of a new ratio are matters of absolute cycle positions, so only the bench's scenarios can show them. The bench sweeps every pair of main and auxiliary codes over several ratios, reprograms the ratio mid-period, resets without reprogramming and runs the largest ratio.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_TERM  = 2'd2
    } refdiv_state_e;

    // Maps a select code to a stream index; out-of-range codes pick the
    // most divided stream, the reversed mapping counts down from it.
    function automatic int refdiv_tap_index(int code, bit reversed, int last);
        int idx;
        if (code > last)
            idx = last;
        else if (reversed)
            idx = last - code;
        else
            idx = code;
        return idx;
    endfunction

endpackage

// File: rtl/refdiv_prescaler.sv
module refdiv_prescaler
    import refdiv_pkg::*;
#(
    parameter int RATIO_W   = 10,
    parameter int MIN_RATIO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ratio_we,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic               term,
    output logic               restart
);

    localparam logic [RATIO_W-1:0] MIN_R   = RATIO_W'(MIN_RATIO);
    localparam logic [RATIO_W-1:0] TWO     = RATIO_W'(2);

    refdiv_state_e      state_q, state_d;
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [RATIO_W-1:0] run_ratio_q, run_ratio_d;
    logic [RATIO_W-1:0] held_ratio_q;

    // Holding register: survives divider reset on purpose.
    always_ff @(posedge clk) begin
        if (ratio_we)
            held_ratio_q <= (ratio_in < MIN_R) ? MIN_R : ratio_in;
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_LOAD;
            cnt_q       <= '0;
            run_ratio_q <= MIN_R;
        end else begin
            state_q     <= state_d;
            cnt_q       <= cnt_d;
            run_ratio_q <= run_ratio_d;
        end
    end

    // Next-state process.
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        run_ratio_d = run_ratio_q;
        unique case (state_q)
            ST_LOAD: begin
                run_ratio_d = held_ratio_q;
                cnt_d       = '0;
                state_d     = ST_COUNT;
            end
            ST_COUNT: begin
                if (cnt_q == run_ratio_q - TWO) begin
                    state_d = ST_TERM;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_TERM: begin
                run_ratio_d = held_ratio_q;
                cnt_d       = '0;
                state_d     = ST_COUNT;
            end
            default: begin
                state_d = ST_LOAD;
            end
        endcase
    end

    // Output process.
    always_comb begin
        term    = (state_q == ST_TERM);
        restart = (state_q == ST_LOAD);
    end

endmodule

// File: rtl/refdiv_chain.sv
module refdiv_chain #(
    parameter int NUM_TAPS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                term,
    input  logic                restart,
    output logic [NUM_TAPS-1:0] tap_pulse
);

    localparam int CW = NUM_TAPS - 1;

    logic [CW-1:0]       stage_q;
    logic [NUM_TAPS-1:0] tap_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage_q <= '0;
        else if (restart)
            stage_q <= '0;
        else if (term)
            stage_q <= stage_q + CW'(1);
    end

    assign tap_hit[0] = 1'b1;

    generate
        for (genvar k = 1; k < NUM_TAPS; k++) begin : g_hit
            assign tap_hit[k] = &stage_q[k-1:0];
        end
    endgenerate

    assign tap_pulse = {NUM_TAPS{term}} & tap_hit;

endmodule

// File: rtl/refdiv_tap_mux.sv
module refdiv_tap_mux
    import refdiv_pkg::*;
#(
    parameter int NUM_TAPS = 5,
    parameter int SEL_W    = 3,
    parameter bit REVERSED = 1'b0
) (
    input  logic [NUM_TAPS-1:0] taps,
    input  logic [SEL_W-1:0]    sel,
    output logic                pulse
);

    localparam int LAST = NUM_TAPS - 1;

    int idx;

    always_comb begin
        idx   = refdiv_tap_index(int'(sel), REVERSED, LAST);
        pulse = 1'b0;
        for (int k = 0; k < NUM_TAPS; k++) begin
            if (idx == k)
                pulse = taps[k];
        end
    end

endmodule

// File: rtl/refdiv_tapsel.sv
module refdiv_tapsel #(
    parameter int RATIO_W   = 10,
    parameter int NUM_TAPS  = 5,
    parameter int SEL_W     = 3,
    parameter int MIN_RATIO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ratio_we,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic [SEL_W-1:0]   main_sel,
    input  logic [SEL_W-1:0]   aux_sel,
    output logic               main_pulse,
    output logic               aux_pulse
);

    logic                term;
    logic                restart;
    logic [NUM_TAPS-1:0] taps;

    refdiv_prescaler #(
        .RATIO_W   (RATIO_W),
        .MIN_RATIO (MIN_RATIO)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_we (ratio_we),
        .ratio_in (ratio_in),
        .term     (term),
        .restart  (restart)
    );

    refdiv_chain #(
        .NUM_TAPS (NUM_TAPS)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .term      (term),
        .restart   (restart),
        .tap_pulse (taps)
    );

    refdiv_tap_mux #(
        .NUM_TAPS (NUM_TAPS),
        .SEL_W    (SEL_W),
        .REVERSED (1'b0)
    ) u_main_mux (
        .taps  (taps),
        .sel   (main_sel),
        .pulse (main_pulse)
    );

    refdiv_tap_mux #(
        .NUM_TAPS (NUM_TAPS),
        .SEL_W    (SEL_W),
        .REVERSED (1'b1)
    ) u_aux_mux (
        .taps  (taps),
        .sel   (aux_sel),
        .pulse (aux_pulse)
    );

endmodule

// File: rtl/refdiv_tapsel_checker.sv
module refdiv_tapsel_checker #(
    parameter int RATIO_W   = 10,
    parameter int NUM_TAPS  = 5,
    parameter int SEL_W     = 3,
    parameter int MIN_RATIO = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             term,
    input logic [SEL_W-1:0] main_sel,
    input logic [SEL_W-1:0] aux_sel,
    input logic             main_pulse,
    input logic             aux_pulse
);

    localparam int          LAST  = NUM_TAPS - 1;
    localparam int          GW    = RATIO_W + 1;
    localparam logic [GW-1:0] GAP_MIN = GW'(MIN_RATIO - 1);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_q <= '0;
        else if (term)
            gap_q <= '0;
        else if (gap_q != '1)
            gap_q <= gap_q + GW'(1);
    end

    assert_main_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        main_pulse |=> !main_pulse);

    assert_aux_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        aux_pulse |=> !aux_pulse);

    assert_pulse_on_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (main_pulse || aux_pulse) |-> term);

    assert_min_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        term |-> (gap_q >= GAP_MIN));

    assert_mirror_codes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(main_sel) <= LAST && int'(aux_sel) <= LAST &&
         int'(main_sel) + int'(aux_sel) == LAST) |-> (main_pulse == aux_pulse));

    assert_high_main_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(main_sel) > LAST && int'(aux_sel) == 0) |-> (main_pulse == aux_pulse));

    assert_high_aux_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(aux_sel) > LAST && int'(main_sel) == LAST) |-> (main_pulse == aux_pulse));

endmodule

bind refdiv_tapsel refdiv_tapsel_checker #(
    .RATIO_W   (RATIO_W),
    .NUM_TAPS  (NUM_TAPS),
    .SEL_W     (SEL_W),
    .MIN_RATIO (MIN_RATIO)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .term       (term),
    .main_sel   (main_sel),
    .aux_sel    (aux_sel),
    .main_pulse (main_pulse),
    .aux_pulse  (aux_pulse)
);

// File: tb/refdiv_tapsel_bench.sv
module refdiv_tapsel_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ratio_we = 1'b0;
    logic [9:0] ratio_in = '0;
    logic [2:0] main_sel = '0;
    logic [2:0] aux_sel = '0;
    logic       main_pulse;
    logic       aux_pulse;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    refdiv_tapsel u_refdiv_tapsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_we   (ratio_we),
        .ratio_in   (ratio_in),
        .main_sel   (main_sel),
        .aux_sel    (aux_sel),
        .main_pulse (main_pulse),
        .aux_pulse  (aux_pulse)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Resets, optionally programs the ratio during reset, then compares both
    // outputs against the arithmetic model for n cycles after release.
    task automatic run_cfg(input int ratio, input bit do_write, input int eff,
                           input int msel, input int asel, input int n,
                           input string mtag, input string atag);
        int mt, at, mp, ap;
        int mbad_i, abad_i, mbad_a, abad_a, unaligned;
        mt = (msel > 4) ? 4 : msel;
        at = (asel > 4) ? 4 : 4 - asel;
        mp = eff << mt;
        ap = eff << at;
        mbad_i = -1; abad_i = -1; mbad_a = 0; abad_a = 0; unaligned = 0;
        @(negedge clk);
        rst_n    = 1'b0;
        ratio_in = 10'(ratio);
        ratio_we = do_write;
        main_sel = 3'(msel);
        aux_sel  = 3'(asel);
        @(negedge clk);
        @(negedge clk);
        ratio_we = 1'b0;
        check("R1", int'(main_pulse) + int'(aux_pulse), 0, "outputs during reset");
        rst_n = 1'b1;
        #1;
        for (int i = 0; i < n; i++) begin
            bit em, ea;
            em = (i > 0) && (i % mp == 0);
            ea = (i > 0) && (i % ap == 0);
            if (main_pulse !== em && mbad_i < 0) begin mbad_i = i; mbad_a = int'(main_pulse); end
            if (aux_pulse  !== ea && abad_i < 0) begin abad_i = i; abad_a = int'(aux_pulse); end
            if ((main_pulse || aux_pulse) && (i % eff != 0)) unaligned++;
            @(negedge clk);
            #1;
        end
        if (mbad_i >= 0) check(mtag, mbad_a, 1 - mbad_a, $sformatf("main ratio=%0d sel=%0d idx=%0d", ratio, msel, mbad_i));
        else             check(mtag, 0, 0, "main");
        if (abad_i >= 0) check(atag, abad_a, 1 - abad_a, $sformatf("aux ratio=%0d sel=%0d idx=%0d", ratio, asel, abad_i));
        else             check(atag, 0, 0, "aux");
        check("R8", unaligned, 0, "pulses off terminal count");
    endtask

    initial begin
        #(4 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ratios[5] = '{0, 3, 4, 5, 7};
        // Sweep of all code pairs: R2/R4/R6 on main, R5/R6 on aux, R3 for small ratios.
        foreach (ratios[r]) begin
            for (int m = 0; m < 8; m++) begin
                for (int a = 0; a < 8; a++) begin
                    int eff;
                    string mtag, atag;
                    eff  = (ratios[r] < 4) ? 4 : ratios[r];
                    mtag = (ratios[r] < 4) ? "R3" : (m > 4) ? "R6" : (m == 0) ? "R2" : "R4";
                    atag = (ratios[r] < 4) ? "R3" : (a > 4) ? "R6" : "R5";
                    run_cfg(ratios[r], 1'b1, eff, m, a, 32 * eff + 1, mtag, atag);
                end
            end
        end

        // R7: write 6 mid-period while running at 4; terminal counts at 4, 8, 14, 20.
        begin
            int bad = 0;
            @(negedge clk);
            rst_n = 1'b0; ratio_in = 10'd4; ratio_we = 1'b1; main_sel = 3'd0; aux_sel = 3'd4;
            @(negedge clk); @(negedge clk);
            ratio_we = 1'b0;
            rst_n = 1'b1;
            #1;
            for (int i = 0; i < 22; i++) begin
                bit em;
                em = (i == 4) || (i == 8) || (i == 14) || (i == 20);
                if (main_pulse !== em) bad++;
                if (i == 5) begin ratio_in = 10'd6; ratio_we = 1'b1; end
                if (i == 6) ratio_we = 1'b0;
                @(negedge clk);
                #1;
            end
            check("R7", bad, 0, "mismatching cycles after mid-run write");
        end

        // R9: reset without reprogramming keeps ratio 6 and restarts every stage.
        run_cfg(0, 1'b0, 6, 2, 1, 6 * 32 + 1, "R9", "R9");

        // R10: largest ratio, main least divided, aux most divided.
        run_cfg(1023, 1'b1, 1023, 0, 0, 16 * 1023 + 1, "R10", "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule